// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns queued characters into asynchronous serial frames on a single TXD line. The frame shape is chosen at run time through one 8-bit configuration register. It sets the character length (5 to 8 bits), one or two stop bits, and whether a parity bit is added. The parity bit can be odd, even, forced high or forced low. The register also holds a line-break override and a transmit gate.

Characters are written into a small transmit FIFO. The serializer takes one when it is idle and the gate is open, and registers the frame format at that moment. The bit timing comes from an external baud-enable strobe: each bit on the line is held for a fixed number of strobes (16 by default). Two status outputs report that the FIFO has room for a new character and that the whole transmit path has gone quiet. Baud generation, the receiver, interrupts and pin multiplexing are left to the surrounding logic.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, txd_o is high and thr_empty_o and tx_empty_o are both 1. The configuration register resets to 8'h01, which means transmit enabled, no break, 5-bit characters, one stop bit and no parity.
- R2: Configuration bits [3:2] set the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. A frame is one low start bit followed by the data bits, least significant first. The line idles high.
- R3: Configuration bit [4] selects the stop bits: 0 sends one high stop bit and 1 sends two.
- R4: Configuration bit [5] enables parity. When it is 1, one parity bit follows the data bits. When it is 0, the stop bits follow the data directly.
- R5: Configuration bits [7:6] set the parity rule. With 00 the data bits plus the parity bit hold an odd number of ones. With 01 they hold an even number.
- R6: Parity code 10 sends a parity bit of 1 and parity code 11 sends a parity bit of 0, whatever the data.
- R7: While configuration bit [1] (break) is 1, txd_o is 0. The frame underneath keeps its timing and resumes on the line when break clears.
- R8: Configuration bit [0] gates transmission. When it is 0, a frame already started finishes, but no further character leaves the FIFO until the bit is 1 again.
- R9: Each frame bit is held on the line for exactly OVERSAMPLE baud_tick_i pulses, counted from the cycle the frame starts. Cycles without a pulse do not change the line.
- R10: thr_empty_o is 1 exactly when the FIFO holds no character. tx_empty_o is 1 exactly when the FIFO is empty and no frame is being sent.
- R11: A pulse on fifo_clr_i drops every pending character and ignores a write in the same cycle. thr_empty_o is 1 on the next cycle.
- R12: The FIFO holds FIFO_DEPTH characters. A write while it is full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Baud-enable strobe, OVERSAMPLE pulses per bit |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 8 | Configuration value {par_type[1:0], par_en, stop2, wlen[1:0], brk, tx_en} |
| wr_valid_i | input | 1 | Write one character into the FIFO |
| wr_data_i | input | 8 | Character to write |
| fifo_clr_i | input | 1 | Clear the transmit FIFO |
| txd_o | output | 1 | Serial output line |
| thr_empty_o | output | 1 | FIFO empty, ready for a new character |
| tx_empty_o | output | 1 | FIFO empty and serializer idle |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and OVERSAMPLE = 16. The shallow FIFO lets a burst of six writes hit the full condition and drop characters within a few cycles. The full oversample count keeps the real bit timing. The strobe runs at every second clock in most tests. One test drives it from an irregular pseudo-random pattern, which checks that bit boundaries follow the strobe count and not the clock count. Every word length, stop count and parity code is sent with data chosen to give both parity polarities.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int CHAR_W  = 8;
  localparam int FRAME_W = 1 + CHAR_W + 1 + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } par_mode_e;

  typedef struct packed {
    par_mode_e   par_type;
    logic        par_en;
    logic        stop2;
    logic [1:0]  wlen;
    logic        brk;
    logic        tx_en;
  } tx_cfg_t;

  localparam tx_cfg_t CFG_RESET = tx_cfg_t'(8'h01);
endpackage

// File: rtl/uart_tx_cfg.sv
module uart_tx_cfg
  import uart_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output tx_cfg_t    cfg_o
);
  tx_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RESET;
    else if (we_i) cfg_q <= tx_cfg_t'(wdata_i);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push, pop;

  assign full_o  = (cnt_q == FULL);
  assign empty_o = (cnt_q == '0);
  assign push    = wr_i && !full_o && !clr_i;
  assign pop     = rd_i && !empty_o && !clr_i;
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [CHAR_W-1:0] data_i,
  input  tx_cfg_t           cfg_i,
  output logic              busy_o,
  output logic              line_o
);
  localparam int TW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [TW-1:0] TLAST = TW'(OVERSAMPLE - 1);

  logic [3:0]         wbits;
  logic               ones, par_bit;
  logic [FRAME_W-1:0] frame_d;
  logic [CNT_W-1:0]   nbits_d;

  logic               busy_q;
  logic [TW-1:0]      tick_q;
  logic [CNT_W-1:0]   left_q;
  logic [FRAME_W-1:0] sh_q;

  assign wbits = 4'd5 + {2'b00, cfg_i.wlen};

  always_comb begin
    ones = 1'b0;
    for (int i = 0; i < CHAR_W; i++)
      if (i < int'(wbits)) ones = ones ^ data_i[i];
    unique case (cfg_i.par_type)
      PAR_ODD:   par_bit = ~ones;
      PAR_EVEN:  par_bit = ones;
      PAR_MARK:  par_bit = 1'b1;
      default:   par_bit = 1'b0;
    endcase
  end

  // start bit at [0], stop bits fill from the default ones
  always_comb begin
    frame_d    = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i <= CHAR_W; i++) begin
      if (i < int'(wbits)) frame_d[1+i] = data_i[i];
      else if (cfg_i.par_en && i == int'(wbits)) frame_d[1+i] = par_bit;
    end
  end

  assign nbits_d = CNT_W'(2) + CNT_W'(wbits) + CNT_W'(cfg_i.par_en) + CNT_W'(cfg_i.stop2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tick_q <= '0;
      left_q <= '0;
      sh_q   <= '1;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      tick_q <= '0;
      left_q <= nbits_d;
      sh_q   <= frame_d;
    end else if (busy_q && tick_i) begin
      if (tick_q == TLAST) begin
        tick_q <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) busy_q <= 1'b0;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign line_o = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       baud_tick_i,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_wdata_i,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  input  logic       fifo_clr_i,
  output logic       txd_o,
  output logic       thr_empty_o,
  output logic       tx_empty_o
);
  tx_cfg_t           cfg;
  logic [CHAR_W-1:0] head;
  logic              empty, full, load, busy, line_bit, tx_en, brk;

  uart_tx_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(CHAR_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fifo_clr_i),
    .wr_i    (wr_valid_i),
    .wdata_i (wr_data_i),
    .rd_i    (load),
    .rdata_o (head),
    .empty_o (empty),
    .full_o  (full)
  );

  assign tx_en = cfg.tx_en;
  assign brk   = cfg.brk;
  assign load  = !busy && !empty && tx_en && !fifo_clr_i;

  uart_tx_shift #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .start_i (load),
    .data_i  (head),
    .cfg_i   (cfg),
    .busy_o  (busy),
    .line_o  (line_bit)
  );

  assign txd_o       = brk ? 1'b0 : line_bit;
  assign thr_empty_o = empty;
  assign tx_empty_o  = empty && !busy;

  logic unused_full;
  assign unused_full = full;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic baud_tick_i,
  input logic fifo_clr_i,
  input logic txd_o,
  input logic thr_empty_o,
  input logic tx_empty_o,
  input logic busy,
  input logic line_bit,
  input logic tx_en,
  input logic brk
);
  p_clr_thre_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> thr_empty_o);

  p_idle_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && !brk) |-> txd_o);

  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy) && !brk) |-> !txd_o);

  p_hold_bit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !baud_tick_i) |=> (busy && $stable(line_bit)));

  p_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en && !busy) |=> !busy);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .baud_tick_i (baud_tick_i),
  .fifo_clr_i  (fifo_clr_i),
  .txd_o       (txd_o),
  .thr_empty_o (thr_empty_o),
  .tx_empty_o  (tx_empty_o),
  .busy        (busy),
  .line_bit    (line_bit),
  .tx_en       (tx_en),
  .brk         (brk)
);

// File: tb/tb_uart_frame_tx.sv
`timescale 1ns/1ps
module tb_uart_frame_tx;
  localparam int DEPTH = 4;
  localparam int OVS   = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       baud_tick_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic       wr_valid_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       fifo_clr_i = 1'b0;
  logic       txd_o, thr_empty_o, tx_empty_o;

  always #10 clk_i = ~clk_i;

  uart_frame_tx #(.FIFO_DEPTH(DEPTH), .OVERSAMPLE(OVS)) dut (
    .clk_i, .rst_ni, .baud_tick_i, .cfg_we_i, .cfg_wdata_i,
    .wr_valid_i, .wr_data_i, .fifo_clr_i, .txd_o, .thr_empty_o, .tx_empty_o
  );

  int    n_vec = 0, n_bad = 0;
  bit    done = 0;
  string cur_req = "R2";

  // stimulus: strobe pattern
  int tick_mode = 0;
  bit tick_phase = 0;
  always @(negedge clk_i) begin
    tick_phase <= ~tick_phase;
    if (tick_mode == 0) baud_tick_i <= tick_phase;
    else                baud_tick_i <= ($urandom_range(0, 2) == 0);
  end

  // behavioural reference
  logic [7:0]  m_q[$];
  logic [7:0]  m_cfg;
  bit          m_busy;
  int          m_tick, m_left;
  logic [15:0] m_frame;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q.delete();
      m_cfg = 8'h01; m_busy = 0; m_tick = 0; m_left = 0; m_frame = '1;
    end else begin
      bit ld, was_full;
      ld       = !m_busy && m_q.size() != 0 && m_cfg[0] && !fifo_clr_i;
      was_full = (m_q.size() == DEPTH);
      if (m_busy && baud_tick_i) begin
        if (m_tick == OVS - 1) begin
          m_tick = 0; m_frame = {1'b1, m_frame[15:1]}; m_left--;
          if (m_left == 0) m_busy = 0;
        end else m_tick++;
      end
      if (ld) begin
        logic [7:0] d;
        int wl, pos;
        bit ones, p;
        d = m_q.pop_front();
        wl = 5 + m_cfg[3:2];
        m_frame = '1; m_frame[0] = 1'b0; ones = 0;
        for (int i = 0; i < wl; i++) begin m_frame[1+i] = d[i]; ones ^= d[i]; end
        pos = 1 + wl;
        case (m_cfg[7:6])
          2'b00: p = !ones;
          2'b01: p = ones;
          2'b10: p = 1;
          default: p = 0;
        endcase
        if (m_cfg[5]) begin m_frame[pos] = p; pos++; end
        m_left = pos + 1 + m_cfg[4];
        m_busy = 1; m_tick = 0;
      end
      if (fifo_clr_i) m_q.delete();
      else if (wr_valid_i && !was_full) m_q.push_back(wr_data_i);
      if (cfg_we_i) m_cfg = cfg_wdata_i;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    #5;
    if (rst_ni && !done) begin
      chk(cur_req, "txd", txd_o, m_cfg[1] ? 1'b0 : (m_busy ? m_frame[0] : 1'b1));
      chk("R10", "thr_empty", thr_empty_o, m_q.size() == 0);
      chk("R10", "tx_empty", tx_empty_o, m_q.size() == 0 && !m_busy);
    end
  end

  function automatic logic [7:0] mk(bit en, bit brk, int wl, bit st, bit pe, int pt);
    return {pt[1:0], pe, st, wl[1:0], brk, en};
  endfunction

  task automatic set_cfg(logic [7:0] v);
    @(negedge clk_i); cfg_we_i = 1; cfg_wdata_i = v;
    @(negedge clk_i); cfg_we_i = 0;
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk_i); wr_valid_i = 1; wr_data_i = b;
    @(negedge clk_i); wr_valid_i = 0;
  endtask

  task automatic drain();
    while (m_q.size() != 0 || m_busy) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic send(logic [7:0] c, logic [7:0] b);
    set_cfg(c); push(b); drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1; n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1", "txd reset", txd_o, 1'b1);
    chk("R1", "thr reset", thr_empty_o, 1'b1);
    chk("R1", "temt reset", tx_empty_o, 1'b1);

    // R1: reset config transmits 5-bit without any write
    cur_req = "R1"; push(8'h15); drain();

    cur_req = "R2";
    for (int wl = 0; wl < 4; wl++) begin
      send(mk(1,0,wl,0,0,0), 8'hA5);
      send(mk(1,0,wl,0,0,0), 8'h3C);
    end
    cur_req = "R3";
    send(mk(1,0,3,1,0,0), 8'h81);
    send(mk(1,0,0,1,1,1), 8'h0E);
    cur_req = "R4";
    send(mk(1,0,3,0,1,0), 8'h00);
    send(mk(1,0,1,0,0,2), 8'h2B);
    cur_req = "R5";
    for (int pt = 0; pt < 2; pt++) begin
      send(mk(1,0,3,0,1,pt), 8'h07);
      send(mk(1,0,3,0,1,pt), 8'h0F);
      send(mk(1,0,2,1,1,pt), 8'hF1);
    end
    cur_req = "R6";
    for (int pt = 2; pt < 4; pt++) begin
      send(mk(1,0,3,0,1,pt), 8'h55);
      send(mk(1,0,0,0,1,pt), 8'h1C);
    end

    cur_req = "R9"; tick_mode = 1;
    set_cfg(mk(1,0,3,1,1,1)); push(8'hC3); push(8'h5A); drain();
    tick_mode = 0;

    cur_req = "R7";
    set_cfg(mk(1,0,3,0,1,0)); push(8'h96);
    repeat (90) @(negedge clk_i);
    set_cfg(mk(1,1,3,0,1,0));
    repeat (2) @(negedge clk_i);
    chk("R7", "txd in break", txd_o, 1'b0);
    repeat (70) @(negedge clk_i);
    set_cfg(mk(1,0,3,0,1,0));
    drain();

    cur_req = "R8";
    set_cfg(mk(1,0,3,0,0,0));
    push(8'h11); push(8'h22); push(8'h33);
    repeat (40) @(negedge clk_i);
    set_cfg(mk(0,0,3,0,0,0));
    repeat (1200) @(negedge clk_i);
    chk("R8", "line idle while gated", txd_o, 1'b1);
    chk("R8", "pending kept", thr_empty_o, 1'b0);
    set_cfg(mk(1,0,3,0,0,0));
    drain();

    cur_req = "R11";
    set_cfg(mk(0,0,3,0,0,0));
    push(8'h44); push(8'h66);
    @(negedge clk_i); fifo_clr_i = 1; wr_valid_i = 1; wr_data_i = 8'h77;
    @(negedge clk_i); fifo_clr_i = 0; wr_valid_i = 0;
    chk("R11", "thr after clear", thr_empty_o, 1'b1);
    set_cfg(mk(1,0,3,0,0,0));
    repeat (400) @(negedge clk_i);
    chk("R11", "nothing sent after clear", tx_empty_o, 1'b1);

    cur_req = "R12";
    set_cfg(mk(0,0,3,0,0,0));
    for (int k = 0; k < DEPTH + 2; k++) push(8'h30 + 8'(k));
    chk("R12", "full not empty", thr_empty_o, 1'b0);
    set_cfg(mk(1,0,3,0,0,0));
    drain();
    chk("R12", "drained", tx_empty_o, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule